// File: doc/BRIEF.md
# Special-Function Register File

This block is a bank of 64 sixteen-bit registers meant for a processor whose only instruction copies one register into another. It has a single combinational read port and a single clocked write port. Most addresses are plain storage. A few addresses, when read, return a value computed from other stored registers instead of their own contents. These computed reads supply an AND-NOT pair, a two-way select, right and left rotates, a ones'-complement adder and an inverter. That is all the computation such a processor has.

Two addresses connect to the world outside the file. A write to address 0 leaves through a display port with a one-cycle valid strobe. Address 63 stands for the program counter. Reads of address 63 return the `pc_value` input, and writes to it raise a one-cycle branch request that carries the written data. All stored registers clear to zero on an active-low reset.

Top module: `sfr_file`

## Requirements
- R1: After reset every stored register holds zero, and `disp_valid` and `branch_valid` are low.
- R2: Reading address 0 returns zero. A write to address 0 drives `disp_valid` high for exactly the following cycle, with `disp_data` equal to the written value, and it changes no stored register.
- R3: Addresses 1 to 52 and address 60 are plain storage. A read returns the last value written there.
- R4: Reading address 53 returns R54 & ~R53. Reading address 54 returns R53 & ~R54. Writes to either address store normally.
- R5: Reading address 55 or 57 returns zero, but writes to these addresses still store their data.
- R6: Reading address 56 returns stored R55 when stored R56 is nonzero. Otherwise it returns stored R57.
- R7: Reading address 58 returns the stored R58 rotated right by one bit, so bit 0 moves to bit 15. Reading address 59 returns the stored R59 rotated left by one bit, so bit 15 moves to bit 0.
- R8: Reading address 61 returns R60 + R61 in ones'-complement arithmetic. The carry out of bit 15 is added back into bit 0.
- R9: Reading address 62 returns the bitwise NOT of the stored R62.
- R10: Reading address 63 returns `pc_value`. A write to address 63 stores nothing. It drives `branch_valid` high for the following cycle, with `branch_target` equal to the written value.
- R11: A computed read never alters any stored register, so repeated reads return the same value.
- R12: While `wr_en` is low, no register changes, whatever `wr_addr` and `wr_data` are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_addr | input | 6 | Read address |
| rd_data | output | 16 | Combinational read result |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 6 | Write address |
| wr_data | input | 16 | Write data |
| pc_value | input | 16 | Current program counter, returned at address 63 |
| disp_data | output | 16 | Last value written to address 0 |
| disp_valid | output | 1 | One-cycle strobe after a write to address 0 |
| branch_target | output | 16 | Value written to address 63 |
| branch_valid | output | 1 | One-cycle strobe after a write to address 63 |

## Verification
The bench drives the ones'-complement adder with a sum that carries out of bit 15. A design that drops the end-around carry returns a result one too small. It checks the select with a condition value whose only set bit is bit 15. A select that tests just the low bit picks the wrong operand. The rotates are loaded with patterns whose end bits must wrap around, which exposes a plain shift or a swapped direction. The bench also confirms that a disabled write, a display write and a branch write leave stored registers untouched, and that a computed read is repeatable. A design that stored on those writes, or that updated a register on a read, would return a changed value.

// File: rtl/sfr_file.sv
`timescale 1ns/1ps
module sfr_file #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [5:0]   rd_addr,
  output logic [W-1:0] rd_data,
  input  logic         wr_en,
  input  logic [5:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] pc_value,
  output logic [W-1:0] disp_data,
  output logic         disp_valid,
  output logic [W-1:0] branch_target,
  output logic         branch_valid
);
  localparam int NREG = 64;
  localparam logic [5:0] A_DISP = 6'd0,  A_MASK_X = 6'd53, A_MASK_Y = 6'd54,
                         A_SEL_T = 6'd55, A_SEL_C = 6'd56, A_SEL_F = 6'd57,
                         A_ROR = 6'd58,  A_ROL = 6'd59,    A_SUM_X = 6'd60,
                         A_SUM_Y = 6'd61, A_INV = 6'd62,   A_PC = 6'd63;

  logic [W-1:0] mem [NREG];
  logic         store_hit;
  logic [W:0]   raw_sum;
  logic [W-1:0] oc_sum;

  assign store_hit = wr_en && wr_addr != A_DISP && wr_addr != A_PC;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
      disp_valid    <= 1'b0;
      disp_data     <= '0;
      branch_valid  <= 1'b0;
      branch_target <= '0;
    end else begin
      if (store_hit) mem[wr_addr] <= wr_data;
      disp_valid   <= wr_en && wr_addr == A_DISP;
      branch_valid <= wr_en && wr_addr == A_PC;
      if (wr_en && wr_addr == A_DISP) disp_data <= wr_data;
      if (wr_en && wr_addr == A_PC) branch_target <= wr_data;
    end
  end

  assign raw_sum = {1'b0, mem[A_SUM_X]} + {1'b0, mem[A_SUM_Y]};
  assign oc_sum  = raw_sum[W-1:0] + {{(W-1){1'b0}}, raw_sum[W]};

  always_comb begin
    case (rd_addr)
      A_DISP, A_SEL_T, A_SEL_F: rd_data = '0;
      A_MASK_X: rd_data = mem[A_MASK_Y] & ~mem[A_MASK_X];
      A_MASK_Y: rd_data = mem[A_MASK_X] & ~mem[A_MASK_Y];
      A_SEL_C:  rd_data = (mem[A_SEL_C] != '0) ? mem[A_SEL_T] : mem[A_SEL_F];
      A_ROR:    rd_data = {mem[A_ROR][0], mem[A_ROR][W-1:1]};
      A_ROL:    rd_data = {mem[A_ROL][W-2:0], mem[A_ROL][W-1]};
      A_SUM_Y:  rd_data = oc_sum;
      A_INV:    rd_data = ~mem[A_INV];
      A_PC:     rd_data = pc_value;
      default:  rd_data = mem[rd_addr];
    endcase
  end

  assert_disp_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_DISP) |=> (disp_valid && disp_data == $past(wr_data)));

  assert_disp_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == A_DISP) |=> !disp_valid);

  assert_branch_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_PC) |=> (branch_valid && branch_target == $past(wr_data)));

  assert_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != A_DISP && wr_addr != A_PC) |=> mem[$past(wr_addr)] == $past(wr_data));

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && rd_addr != A_PC) |=> (rd_addr != $past(rd_addr) || rd_data == $past(rd_data)));
endmodule

// File: tb/tb_sfr_file.sv
`timescale 1ns/1ps
module tb_sfr_file;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  rd_addr = '0, wr_addr = '0;
  logic [15:0] wr_data = '0, pc_value = 16'h0ABC;
  logic        wr_en = 1'b0;
  logic [15:0] rd_data, disp_data, branch_target;
  logic        disp_valid, branch_valid;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sfr_file dut (.clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .pc_value(pc_value),
    .disp_data(disp_data), .disp_valid(disp_valid),
    .branch_target(branch_target), .branch_valid(branch_valid));

  // fields: wr_en, wr_addr, wr_data, rd_addr, expected, requirement
  localparam int NV = 21;
  localparam logic [48:0] VEC [NV] = '{
    {1'b1, 6'd1,  16'h1234, 6'd1,  16'h1234, 4'd3},   // R3
    {1'b1, 6'd52, 16'hBEEF, 6'd52, 16'hBEEF, 4'd3},   // R3
    {1'b1, 6'd60, 16'h00FF, 6'd60, 16'h00FF, 4'd3},   // R3
    {1'b1, 6'd53, 16'h0F0F, 6'd53, 16'h0000, 4'd4},   // R4
    {1'b1, 6'd54, 16'h3C3C, 6'd53, 16'h3030, 4'd4},   // R4
    {1'b0, 6'd0,  16'h0000, 6'd54, 16'h0303, 4'd4},   // R4
    {1'b1, 6'd55, 16'hAAAA, 6'd55, 16'h0000, 4'd5},   // R5
    {1'b1, 6'd57, 16'h5555, 6'd57, 16'h0000, 4'd5},   // R5
    {1'b0, 6'd0,  16'h0000, 6'd56, 16'h5555, 4'd6},   // R6
    {1'b1, 6'd56, 16'h0001, 6'd56, 16'hAAAA, 4'd6},   // R6
    {1'b1, 6'd56, 16'h8000, 6'd56, 16'hAAAA, 4'd6},   // R6
    {1'b1, 6'd58, 16'h0003, 6'd58, 16'h8001, 4'd7},   // R7
    {1'b1, 6'd59, 16'h8001, 6'd59, 16'h0003, 4'd7},   // R7
    {1'b1, 6'd61, 16'h0001, 6'd61, 16'h0100, 4'd8},   // R8
    {1'b1, 6'd60, 16'hFFFE, 6'd61, 16'hFFFF, 4'd8},   // R8
    {1'b1, 6'd61, 16'h0005, 6'd61, 16'h0004, 4'd8},   // R8
    {1'b1, 6'd62, 16'h1234, 6'd62, 16'hEDCB, 4'd9},   // R9
    {1'b0, 6'd0,  16'h0000, 6'd63, 16'h0ABC, 4'd10},  // R10
    {1'b0, 6'd1,  16'hFFFF, 6'd1,  16'h1234, 4'd12},  // R12
    {1'b0, 6'd0,  16'h0000, 6'd58, 16'h8001, 4'd11},  // R11
    {1'b0, 6'd0,  16'h0000, 6'd0,  16'h0000, 4'd2}    // R2
  };

  task automatic chk(input int req, input logic [15:0] act, input logic [15:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [5:0] wa, input logic [15:0] wd, input logic [5:0] ra);
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R1: reset state
    rd_addr = 6'd1;  #1 chk(1, rd_data, 16'h0000, "R1 reg1 after reset");
    rd_addr = 6'd60; #1 chk(1, rd_data, 16'h0000, "R1 reg60 after reset");
    rd_addr = 6'd62; #1 chk(1, rd_data, 16'hFFFF, "R1 reg62 inverted zero");
    chk(1, {15'd0, disp_valid}, 16'd0, "R1 disp_valid low");
    chk(1, {15'd0, branch_valid}, 16'd0, "R1 branch_valid low");

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][48], VEC[i][47:42], VEC[i][41:26], VEC[i][25:20]);
      chk(int'(VEC[i][3:0]), rd_data, VEC[i][19:4], $sformatf("vector %0d", i));
    end

    // R2: display write strobes once and stores nothing
    step(1'b1, 6'd0, 16'h00C3, 6'd1);
    chk(2, {15'd0, disp_valid}, 16'd1, "R2 disp_valid after write");
    chk(2, disp_data, 16'h00C3, "R2 disp_data");
    chk(2, rd_data, 16'h1234, "R2 reg1 untouched");
    step(1'b0, 6'd0, 16'h0000, 6'd0);
    chk(2, {15'd0, disp_valid}, 16'd0, "R2 disp_valid drops");
    chk(2, rd_data, 16'h0000, "R2 read of address 0");

    // R10: branch write strobes, read still tracks pc_value
    pc_value = 16'h0042;
    step(1'b1, 6'd63, 16'h0040, 6'd63);
    chk(10, {15'd0, branch_valid}, 16'd1, "R10 branch_valid");
    chk(10, branch_target, 16'h0040, "R10 branch_target");
    chk(10, rd_data, 16'h0042, "R10 read returns pc_value");
    step(1'b0, 6'd0, 16'h0000, 6'd62);
    chk(10, {15'd0, branch_valid}, 16'd0, "R10 branch_valid drops");
    chk(10, rd_data, 16'hEDCB, "R10 reg62 untouched by branch write");

    // R11: repeated computed reads are stable
    step(1'b0, 6'd0, 16'h0000, 6'd59);
    chk(11, rd_data, 16'h0003, "R11 rol first read");
    step(1'b0, 6'd0, 16'h0000, 6'd59);
    chk(11, rd_data, 16'h0003, "R11 rol second read");

    // R1: reset clears again
    @(negedge clk) rst_n = 1'b0;
    @(posedge clk); #1;
    @(negedge clk) rst_n = 1'b1; rd_addr = 6'd52;
    #1 chk(1, rd_data, 16'h0000, "R1 reg52 after second reset");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule